// File: doc/BRIEF.md
# IO Address Window Decoder

This block sorts outgoing IO accesses by address. It takes a 48-bit physical request address and reports which target the address belongs to. The targets come from a bank of programmable windows. Each window has a lower bound, an upper bound, an enable flag and a target identifier, and the bounds work at 1 MB granularity. An address that no enabled window covers falls through to a default target, which is held in one global register.

Configuration software programs the windows through a plain 32-bit word read/write port. The decoder compares the request address against every window on every clock cycle. The result is registered: a hit flag, the target identifier and the index of the winning window. Window 0 is normally kept for boot firmware, but the hardware decodes it the same way as every other window.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, dec_hit, dec_target and dec_win are 0. Every register reads 0. Every window is disabled and the default target is 0.
- R2: Window n occupies byte offsets 0x10*n to 0x10*n+0xF. The layout within a window is as follows.
  - Offset +0x0 is the lower bound. Bits [31:4] hold address bits [47:20] and bit 0 is the enable flag.
  - Offset +0x8 is the upper bound. Bits [31:4] hold address bits [47:20].
  - Offset +0xC holds the 4-bit target in bits [3:0].
  - The default target register sits at 0x10*NUM_WIN (0x100) and uses bits [3:0].
  - A register reads back what was written, with every unused bit read as 0.
- R3: The following accesses are ignored: writes to offset +0x4 of a window, writes at or beyond 0x104, and writes whose address bits [1:0] are nonzero. Each of these reads back 0 and leaves every other register unchanged.
- R4: An enabled window matches when address[47:20] is at least its lower field and at most its upper field. Both bounds are inclusive, and address[19:0] plays no part in the match.
- R5: A window whose enable bit is 0 never matches.
- R6: On a hit, dec_target equals the target register of the winning window and dec_win equals its index.
- R7: When several enabled windows match, the window with the lowest number wins.
- R8: When no enabled window matches, dec_hit is 0, dec_win is 0 and dec_target equals the default target.
- R9: The decode result appears on the outputs one clock edge after the address is presented. A register write affects the decode that is sampled at the next clock edge.
- R10: Window 0 decodes like any other window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_addr | input | 48 | Physical address to decode |
| dec_hit | output | 1 | An enabled window matched |
| dec_target | output | 4 | Target identifier of the winner, or the default target |
| dec_win | output | 4 | Index of the winning window, 0 on a miss |

## Verification
The assertions assume that req_addr and the window registers are stable around each clock edge. They also assume that the upper bound may be set below the lower bound, which leaves that window empty and never matching. The random stimulus chooses bounds and address fields from a small shared range so that windows overlap often, and it sometimes sets the upper bound below the lower one. All inputs are driven on the falling clock edge, so the assumption of stable values at the sampling edge holds.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // word slot inside a window's 16-byte group; the positions are decoded
  typedef enum logic [1:0] {
    SLOT_LO  = 2'd0,
    SLOT_GAP = 2'd1,
    SLOT_HI  = 2'd2,
    SLOT_CTL = 2'd3
  } slot_e;

  localparam int EN_BIT  = 0;   // enable flag inside the lower-bound word
  localparam int FLD_LSB = 4;   // address field starts here in a bound word
  localparam int GRAN_SH = 20;  // 1 MB granularity
endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int TGT_W   = 4,
  parameter int FLD_W   = 28,
  parameter int RADDR_W = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [RADDR_W-1:0]             addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata,
  output logic [NUM_WIN-1:0]             win_en,
  output logic [NUM_WIN-1:0][FLD_W-1:0]  win_lo,
  output logic [NUM_WIN-1:0][FLD_W-1:0]  win_hi,
  output logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt,
  output logic [TGT_W-1:0]               dflt_tgt
);
  localparam int IDX_W = RADDR_W - 4;

  logic [IDX_W-1:0] idx;
  slot_e            slot;
  logic             aligned;
  logic             win_sel;
  logic             glb_sel;

  assign idx     = addr[RADDR_W-1:4];
  assign slot    = slot_e'(addr[3:2]);
  assign aligned = (addr[1:0] == 2'b00);
  assign win_sel = aligned && (int'(idx) < NUM_WIN);
  assign glb_sel = aligned && (int'(idx) == NUM_WIN) && (slot == SLOT_LO);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic             sel_w;
    logic             ld_lo, ld_hi, ld_tg;
    logic             en_d, en_q;
    logic [FLD_W-1:0] lo_d, lo_q, hi_d, hi_q;
    logic [TGT_W-1:0] tg_d, tg_q;

    assign sel_w = we && win_sel && (int'(idx) == w);

    always_comb begin
      ld_lo = sel_w && (slot == SLOT_LO);
      ld_hi = sel_w && (slot == SLOT_HI);
      ld_tg = sel_w && (slot == SLOT_CTL);
      lo_d  = wdata[FLD_LSB +: FLD_W];
      en_d  = wdata[EN_BIT];
      hi_d  = wdata[FLD_LSB +: FLD_W];
      tg_d  = wdata[TGT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        lo_q <= '0;
        hi_q <= '0;
        tg_q <= '0;
      end else begin
        if (ld_lo) begin
          en_q <= en_d;
          lo_q <= lo_d;
        end
        if (ld_hi) hi_q <= hi_d;
        if (ld_tg) tg_q <= tg_d;
      end
    end

    assign win_en[w]  = en_q;
    assign win_lo[w]  = lo_q;
    assign win_hi[w]  = hi_q;
    assign win_tgt[w] = tg_q;
  end

  logic             ld_glb;
  logic [TGT_W-1:0] glb_d;

  always_comb begin
    ld_glb = we && glb_sel;
    glb_d  = wdata[TGT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dflt_tgt <= '0;
    else if (ld_glb) dflt_tgt <= glb_d;
  end

  always_comb begin
    rdata = '0;
    if (win_sel) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(idx) == w) begin
          case (slot)
            SLOT_LO: begin
              rdata[FLD_LSB +: FLD_W] = win_lo[w];
              rdata[EN_BIT]           = win_en[w];
            end
            SLOT_HI:  rdata[FLD_LSB +: FLD_W] = win_hi[w];
            SLOT_CTL: rdata[TGT_W-1:0]        = win_tgt[w];
            default:  rdata = '0;
          endcase
        end
      end
    end
    if (glb_sel) rdata[TGT_W-1:0] = dflt_tgt;
  end
endmodule

// File: rtl/iowin_cmp.sv
module iowin_cmp #(
  parameter int FLD_W = 28
) (
  input  logic [FLD_W-1:0] addr_fld,
  input  logic             en,
  input  logic [FLD_W-1:0] lo,
  input  logic [FLD_W-1:0] hi,
  output logic             hit
);
  logic ge_lo, le_hi;

  assign ge_lo = (addr_fld >= lo);
  assign le_hi = (addr_fld <= hi);
  assign hit   = en && ge_lo && le_hi;
endmodule

// File: rtl/iowin_pick.sv
module iowin_pick #(
  parameter int NUM_WIN = 16,
  parameter int TGT_W   = 4,
  parameter int WIN_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WIN-1:0]            hit_vec,
  input  logic [NUM_WIN-1:0][TGT_W-1:0] tgt,
  input  logic [TGT_W-1:0]              dflt,
  output logic                          out_hit,
  output logic [TGT_W-1:0]              out_tgt,
  output logic [WIN_W-1:0]              out_win
);
  logic             hit_n;
  logic [TGT_W-1:0] tgt_n;
  logic [WIN_W-1:0] win_n;

  // scan downward so the lowest matching index is the last to assign
  always_comb begin
    hit_n = 1'b0;
    tgt_n = dflt;
    win_n = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_n = 1'b1;
        tgt_n = tgt[w];
        win_n = WIN_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hit <= 1'b0;
      out_tgt <= '0;
      out_win <= '0;
    end else begin
      out_hit <= hit_n;
      out_tgt <= tgt_n;
      out_win <= win_n;
    end
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int TGT_W   = 4,
  parameter int ADDR_W  = 48,
  parameter int RADDR_W = $clog2(NUM_WIN * 16 + 16),
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               dec_hit,
  output logic [TGT_W-1:0]   dec_target,
  output logic [WIN_W-1:0]   dec_win
);
  localparam int FLD_W = ADDR_W - GRAN_SH;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sh;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q = rst_sh[1];

  logic [NUM_WIN-1:0]            win_en;
  logic [NUM_WIN-1:0][FLD_W-1:0] win_lo;
  logic [NUM_WIN-1:0][FLD_W-1:0] win_hi;
  logic [NUM_WIN-1:0][TGT_W-1:0] win_tgt;
  logic [TGT_W-1:0]              dflt_tgt;
  logic [NUM_WIN-1:0]            hit_vec;
  logic [FLD_W-1:0]              addr_fld;

  assign addr_fld = req_addr[ADDR_W-1:GRAN_SH];

  iowin_regfile #(
    .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .FLD_W(FLD_W), .RADDR_W(RADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .win_en  (win_en),
    .win_lo  (win_lo),
    .win_hi  (win_hi),
    .win_tgt (win_tgt),
    .dflt_tgt(dflt_tgt)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    iowin_cmp #(.FLD_W(FLD_W)) u_cmp (
      .addr_fld(addr_fld),
      .en      (win_en[w]),
      .lo      (win_lo[w]),
      .hi      (win_hi[w]),
      .hit     (hit_vec[w])
    );
  end

  iowin_pick #(
    .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .WIN_W(WIN_W)
  ) u_pick (
    .clk    (clk),
    .rst_n  (rst_q),
    .hit_vec(hit_vec),
    .tgt    (win_tgt),
    .dflt   (dflt_tgt),
    .out_hit(dec_hit),
    .out_tgt(dec_target),
    .out_win(dec_win)
  );
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int NUM_WIN = 16,
  parameter int TGT_W   = 4,
  parameter int FLD_W   = 28,
  parameter int WIN_W   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [FLD_W-1:0]              addr_fld,
  input logic [NUM_WIN-1:0]            win_en,
  input logic [NUM_WIN-1:0][FLD_W-1:0] win_lo,
  input logic [NUM_WIN-1:0][FLD_W-1:0] win_hi,
  input logic [NUM_WIN-1:0][TGT_W-1:0] win_tgt,
  input logic [TGT_W-1:0]              dflt_tgt,
  input logic                          dec_hit,
  input logic [TGT_W-1:0]              dec_target,
  input logic [WIN_W-1:0]              dec_win
);
  // copy of the decode inputs seen at the previous edge
  logic [FLD_W-1:0]              q_fld;
  logic [NUM_WIN-1:0]            q_en;
  logic [NUM_WIN-1:0][FLD_W-1:0] q_lo, q_hi;
  logic [NUM_WIN-1:0][TGT_W-1:0] q_tg;
  logic [TGT_W-1:0]              q_df;

  always_ff @(posedge clk) begin
    q_fld <= addr_fld;
    q_en  <= win_en;
    q_lo  <= win_lo;
    q_hi  <= win_hi;
    q_tg  <= win_tgt;
    q_df  <= dflt_tgt;
  end

  logic             sel_en;
  logic             sel_in;
  logic [TGT_W-1:0] sel_tg;
  logic             lower_match;

  always_comb begin
    sel_en      = 1'b0;
    sel_in      = 1'b0;
    sel_tg      = '0;
    lower_match = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (int'(dec_win) == w) begin
        sel_en = q_en[w];
        sel_in = (q_fld >= q_lo[w]) && (q_fld <= q_hi[w]);
        sel_tg = q_tg[w];
      end
      if ((w < int'(dec_win)) && q_en[w] && (q_fld >= q_lo[w]) && (q_fld <= q_hi[w]))
        lower_match = 1'b1;
    end
  end

  // R5
  enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> sel_en);

  // R4
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> sel_in);

  // R6
  target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (dec_target == sel_tg));

  // R7
  lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> !lower_match);

  // R8
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_win == '0) && (dec_target == q_df));
endmodule

bind iowin_decoder iowin_decoder_chk #(
  .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .FLD_W(FLD_W), .WIN_W(WIN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_fld  (addr_fld),
  .win_en    (win_en),
  .win_lo    (win_lo),
  .win_hi    (win_hi),
  .win_tgt   (win_tgt),
  .dflt_tgt  (dflt_tgt),
  .dec_hit   (dec_hit),
  .dec_target(dec_target),
  .dec_win   (dec_win)
);

// File: tb/iowin_decoder_bench.sv
`timescale 1ns/1ps
module iowin_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [47:0] req_addr;
  logic        dec_hit;
  logic [3:0]  dec_target;
  logic [3:0]  dec_win;

  always #2.5 clk = ~clk;

  iowin_decoder u_iowin_decoder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
    .dec_hit(dec_hit), .dec_target(dec_target), .dec_win(dec_win)
  );

  int n_chk = 0;
  int n_err = 0;

  // model of the register contents, per the requirements
  logic        m_en [16];
  logic [27:0] m_lo [16];
  logic [27:0] m_hi [16];
  logic [3:0]  m_tg [16];
  logic [3:0]  m_df;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [8:0] a, input logic [31:0] d);
    int idx;
    idx = int'(a[8:4]);
    if (a[1:0] != 2'b00) return;
    if (idx < 16) begin
      case (a[3:2])
        2'd0: begin m_lo[idx] = d[31:4]; m_en[idx] = d[0]; end
        2'd2: m_hi[idx] = d[31:4];
        2'd3: m_tg[idx] = d[3:0];
        default: ;
      endcase
    end else if (idx == 16 && a[3:2] == 2'd0) begin
      m_df = d[3:0];
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [8:0] exp_dec(input logic [47:0] a);
    logic [8:0] r;
    r = {1'b0, 4'd0, m_df};
    for (int w = 15; w >= 0; w--)
      if (m_en[w] && a[47:20] >= m_lo[w] && a[47:20] <= m_hi[w])
        r = {1'b1, 4'(w), m_tg[w]};
    return r;
  endfunction

  task automatic dec_chk(input string req, input logic [47:0] a);
    logic [8:0] e;
    @(negedge clk);
    req_addr = a;
    e = exp_dec(a);
    @(negedge clk);
    check(req, {23'd0, dec_hit, dec_win, dec_target}, {23'd0, e});
  endtask

  task automatic set_win(input int w, input logic [27:0] lo, input logic [27:0] hi,
                         input logic en, input logic [3:0] tg);
    wr(9'(w * 16 + 8), {hi, 4'h0});
    wr(9'(w * 16 + 12), {28'd0, tg});
    wr(9'(w * 16), {lo, 3'b000, en});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1EAF_0007));
    for (int w = 0; w < 16; w++) begin m_en[w] = 0; m_lo[w] = 0; m_hi[w] = 0; m_tg[w] = 0; end
    m_df = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; req_addr = 48'h1234_5678_9ABC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 outputs", {23'd0, dec_hit, dec_win, dec_target}, 32'd0);
    rd_chk("R1 win0 low", 9'h000, 32'd0);
    rd_chk("R1 win5 high", 9'h058, 32'd0);
    rd_chk("R1 default", 9'h100, 32'd0);
    dec_chk("R1 decode miss", 48'h0000_0010_0000);

    // R2: layout and read-back with unused bits zero
    wr(9'h030, 32'hFFFF_FFFE);
    rd_chk("R2 low field", 9'h030, 32'hFFFF_FFF0);
    wr(9'h038, 32'hFFFF_FFFF);
    rd_chk("R2 high", 9'h038, 32'hFFFF_FFF0);
    wr(9'h03C, 32'hFFFF_FFFF);
    rd_chk("R2 ctl", 9'h03C, 32'h0000_000F);
    wr(9'h100, 32'hFFFF_FFFA);
    rd_chk("R2 default", 9'h100, 32'h0000_000A);
    wr(9'h030, 32'h0000_0031);
    rd_chk("R2 enable bit", 9'h030, 32'h0000_0031);

    // R3: ignored accesses
    wr(9'h034, 32'hDEAD_BEEF);
    rd_chk("R3 gap reads 0", 9'h034, 32'd0);
    rd_chk("R3 gap leaves low", 9'h030, 32'h0000_0031);
    wr(9'h104, 32'h0000_0005);
    rd_chk("R3 beyond reads 0", 9'h104, 32'd0);
    rd_chk("R3 beyond leaves default", 9'h100, 32'h0000_000A);
    wr(9'h031, 32'h0000_0FF0);
    rd_chk("R3 misaligned ignored", 9'h030, 32'h0000_0031);
    wr(9'h03D, 32'h0000_0002);
    rd_chk("R3 misaligned ctl ignored", 9'h03C, 32'h0000_000F);
    set_win(3, 28'd0, 28'd0, 1'b0, 4'd0);

    // R4: inclusive bounds
    set_win(2, 28'h10, 28'h12, 1'b1, 4'd5);
    dec_chk("R4 below low", {28'h0F, 20'hFFFFF});
    dec_chk("R4 at low", {28'h10, 20'h00000});
    dec_chk("R4 at high top", {28'h12, 20'hFFFFF});
    dec_chk("R4 above high", {28'h13, 20'h00000});
    check("R8 miss default", {28'd0, dec_target}, 32'hA);

    // R5: disabled window never matches
    wr(9'h020, {28'h10, 4'h0});
    dec_chk("R5 disabled", {28'h11, 20'h0});
    check("R5 hit low", {31'd0, dec_hit}, 32'd0);
    wr(9'h020, {28'h10, 4'h1});

    // R10 and R7: window 0 decodes and wins over overlapping ones
    set_win(0, 28'h11, 28'h11, 1'b1, 4'd7);
    set_win(5, 28'h00, 28'h20, 1'b1, 4'd9);
    dec_chk("R10 window 0 hit", {28'h11, 20'h12345});
    check("R7 lowest wins", {28'd0, dec_win}, 32'd0);
    dec_chk("R7 win2 over win5", {28'h12, 20'h0});
    check("R6 target of win2", {28'd0, dec_target}, 32'd5);
    dec_chk("R6 win5 only", {28'h20, 20'h0});

    // R9: one edge of latency, write visible at the next decode
    @(negedge clk);
    req_addr = {28'h11, 20'h0};
    @(negedge clk);
    req_addr = {28'h7F, 20'h0};
    #1;
    check("R9 output held until edge", {23'd0, dec_hit, dec_win, dec_target}, {23'd0, 1'b1, 4'd0, 4'd7});
    @(negedge clk);
    check("R9 new result after edge", {23'd0, dec_hit, dec_win, dec_target}, {23'd0, exp_dec({28'h7F, 20'h0})});
    wr(9'h000, {28'h11, 4'h0});
    req_addr = {28'h11, 20'h0};
    @(negedge clk);
    check("R9 write seen next decode", {23'd0, dec_hit, dec_win, dec_target}, {23'd0, 1'b1, 4'd2, 4'd5});

    // random overlapping windows
    for (int it = 0; it < 600; it++) begin
      if (it % 100 == 0) begin
        for (int w = 0; w < 16; w++) begin
          logic [27:0] lo;
          logic [27:0] hi;
          lo = 28'($urandom_range(0, 63));
          hi = ($urandom_range(0, 7) == 0) ? lo - 28'd1 : lo + 28'($urandom_range(0, 15));
          set_win(w, lo, hi, 1'($urandom_range(0, 3) != 0), 4'($urandom));
        end
        wr(9'h100, 32'($urandom));
      end
      begin
        logic [47:0] a;
        a = {28'($urandom_range(0, 90)), 20'($urandom)};
        if ($urandom_range(0, 15) == 0) a = {$urandom, 16'($urandom)};
        dec_chk("R4 R6 R7 R8 random", a);
      end
    end

    finish_run();
  end
endmodule